// File: doc/BRIEF.md
# Variable-Precision Distributed Arithmetic Dot-Product Unit

This block forms the inner product of four signed 8-bit samples with a fixed set of four coefficients and uses no multiplier. An external agent fills a 16-entry table with every sum of a subset of the coefficients. The table address is built from one bit of each sample, all four bits of the same weight. The samples are loaded in parallel into per-element shift registers. After a start request the block applies one bit-slice per cycle, most significant first. On each cycle the running sum is doubled and the table entry is added to it. On the slice that carries the sign bits, the entry is subtracted instead.

A precision field, captured with each load, selects how many of the high-order bits are processed. The shift-register stages below that point are neither loaded nor shifted, and a bypass feeds zero into the lowest active stage. A run over K bits therefore takes K cycles. Its result is scaled back to full weight, so it equals the exact dot product of the samples with their low 8-K bits cleared. Cutting the bit count trades accuracy for fewer cycles and less switching. Because the slices arrive most significant first, a short run still gives a close estimate.

Top module: `da_unit`

## Requirements
- R1: After reset, busy_o and done_o are low and result_o is zero.
- R2: Table entry a, written through tbl_we_i/tbl_addr_i/tbl_data_i, is used for the slice in which bit i of address a equals the current bit of sample i. Sample i sits at samples_i[8*i+7:8*i]. With full precision, result_o equals the exact signed dot product sum(coef_i * x_i) when entry a holds the sum of coef_i over the set bits i of a.
- R3: The slice holding the sample sign bits is subtracted from the running sum, so negative samples give the correct signed result.
- R4: prec_i, captured when load_i is accepted, selects K = prec_i + 1 processed bits (1 to 8). result_o equals the dot product with each sample's low 8-K bits cleared, at full-scale weight.
- R5: start_i is accepted when busy_o is low and load_i is low. busy_o is high from the accepting edge until done_o rises. done_o is high for exactly one cycle, set on the K-th edge after the accepting edge. If start_i and load_i are high in the same idle cycle, the load is taken and no run starts.
- R6: load_i while busy_o is high changes neither the samples nor the precision of the run in progress.
- R7: start_i while busy_o is high neither restarts nor extends the run.
- R8: result_o changes only on the cycle that done_o rises, and holds its value until the next completion.
- R9: Rewriting table entries changes the results of later runs.
- R10: The accumulator is wide enough (21 bits) that extreme samples and table entries with magnitude near 2047 yield the exact result without overflow.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| load_i | input | 1 | Capture samples_i and prec_i (idle only) |
| samples_i | input | 32 | Four signed 8-bit samples, sample i at bits 8i+7:8i |
| prec_i | input | 3 | Processed bit count minus one |
| tbl_we_i | input | 1 | Table write enable |
| tbl_addr_i | input | 4 | Table write address |
| tbl_data_i | input | 12 | Signed table entry |
| start_i | input | 1 | Begin a run |
| busy_o | output | 1 | Run in progress |
| done_o | output | 1 | One-cycle completion pulse |
| result_o | output | 21 | Signed, left-aligned dot product |

## Verification
A wrong slice order, a missed sign subtraction or a bad bypass input corrupts the accumulator. Because result_o is registered only on completion, the error shows there within K cycles of the start. The bench checks every precision from 1 to 8 against a direct multiply-accumulate of the truncated samples. A control error, such as a wrong cycle count or a load or start taken while busy, shows as done_o arriving on the wrong cycle or a result matching the wrong samples. A missed table write shows as a wrong result on the next run.

// File: rtl/da_pkg.sv
package da_pkg;
  localparam int unsigned DEF_NUM_TAPS = 4;
  localparam int unsigned DEF_MAX_BITS = 8;
  localparam int unsigned DEF_COEF_W   = 12;

  typedef enum logic {ACC_ADD = 1'b0, ACC_SUB = 1'b1} acc_op_e;
endpackage

// File: rtl/da_lut.sv
module da_lut #(
  parameter int unsigned ADDR_W = 4,
  parameter int unsigned DATA_W = 12
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              we_i,
  input  logic [ADDR_W-1:0] waddr_i,
  input  logic [DATA_W-1:0] wdata_i,
  input  logic [ADDR_W-1:0] raddr_i,
  output logic [DATA_W-1:0] rdata_o
);
  localparam int unsigned DEPTH = 1 << ADDR_W;

  logic [DATA_W-1:0] mem_q [DEPTH];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      for (int k = 0; k < DEPTH; k++) mem_q[k] <= '0;
    end else if (we_i) begin
      mem_q[waddr_i] <= wdata_i;
    end
  end

  assign rdata_o = mem_q[raddr_i];
endmodule

// File: rtl/da_slice_sreg.sv
module da_slice_sreg #(
  parameter int unsigned MAX_BITS = 8,
  parameter int unsigned IDX_W    = 3
) (
  input  logic                clk_i,
  input  logic                rst_ni,
  input  logic                load_i,
  input  logic                shift_i,
  input  logic [IDX_W-1:0]    load_prec_i,
  input  logic [IDX_W-1:0]    run_prec_i,
  input  logic [MAX_BITS-1:0] data_i,
  output logic                msb_o
);
  logic [MAX_BITS-1:0] sr_q;

  for (genvar j = 0; j < MAX_BITS; j++) begin : g_stage
    logic ld_en, sh_en, sh_in, bit_q;
    // stage is live only when it falls within the top K positions
    assign ld_en = load_i  && (j + int'(load_prec_i) >= int'(MAX_BITS) - 1);
    assign sh_en = shift_i && (j + int'(run_prec_i)  >= int'(MAX_BITS) - 1);
    if (j == 0) begin : g_bot
      assign sh_in = 1'b0;
    end else begin : g_mid
      // bypass: lowest live stage takes zero instead of a dead neighbour
      assign sh_in = (j - 1 + int'(run_prec_i) >= int'(MAX_BITS) - 1) ? sr_q[j-1] : 1'b0;
    end
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)    bit_q <= 1'b0;
      else if (ld_en) bit_q <= data_i[j];
      else if (sh_en) bit_q <= sh_in;
    end
    assign sr_q[j] = bit_q;
  end

  assign msb_o = sr_q[MAX_BITS-1];
endmodule

// File: rtl/da_ctrl.sv
module da_ctrl #(
  parameter int unsigned IDX_W = 3
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             start_i,
  input  logic             load_i,
  input  logic [IDX_W-1:0] prec_i,
  output logic             accept_o,
  output logic             step_o,
  output logic             first_o,
  output logic             last_o,
  output logic             busy_o,
  output logic             done_o
);
  logic             busy_q, done_q;
  logic [IDX_W-1:0] cnt_q;

  assign accept_o = start_i && !load_i && !busy_q;
  assign step_o   = busy_q;
  assign first_o  = busy_q && (cnt_q == '0);
  assign last_o   = busy_q && (cnt_q == prec_i);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      busy_q <= 1'b0;
      done_q <= 1'b0;
      cnt_q  <= '0;
    end else begin
      done_q <= 1'b0;
      if (accept_o) begin
        busy_q <= 1'b1;
        cnt_q  <= '0;
      end else if (busy_q) begin
        cnt_q <= cnt_q + 1'b1;
        if (last_o) begin
          busy_q <= 1'b0;
          done_q <= 1'b1;
        end
      end
    end
  end

  assign busy_o = busy_q;
  assign done_o = done_q;
endmodule

// File: rtl/da_accum.sv
module da_accum #(
  parameter int unsigned COEF_W = 12,
  parameter int unsigned ACC_W  = 21,
  parameter int unsigned IDX_W  = 3
) (
  input  logic                     clk_i,
  input  logic                     rst_ni,
  input  logic                     clear_i,
  input  logic                     step_i,
  input  da_pkg::acc_op_e          op_i,
  input  logic                     last_i,
  input  logic [COEF_W-1:0]        entry_i,
  input  logic [IDX_W-1:0]         align_i,
  output logic signed [ACC_W-1:0]  result_o
);
  logic signed [ACC_W-1:0] acc_q, res_q, ent_x, dbl, nxt;

  assign ent_x = {{(ACC_W-COEF_W){entry_i[COEF_W-1]}}, entry_i};
  assign dbl   = acc_q <<< 1;
  assign nxt   = (op_i == da_pkg::ACC_SUB) ? dbl - ent_x : dbl + ent_x;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      acc_q <= '0;
      res_q <= '0;
    end else begin
      if (clear_i)     acc_q <= '0;
      else if (step_i) acc_q <= nxt;
      if (last_i)      res_q <= nxt <<< align_i;
    end
  end

  assign result_o = res_q;
endmodule

// File: rtl/da_unit.sv
module da_unit #(
  parameter int unsigned NUM_TAPS = da_pkg::DEF_NUM_TAPS,
  parameter int unsigned MAX_BITS = da_pkg::DEF_MAX_BITS,
  parameter int unsigned COEF_W   = da_pkg::DEF_COEF_W,
  localparam int unsigned ADDR_W  = NUM_TAPS,
  localparam int unsigned IDX_W   = $clog2(MAX_BITS),
  localparam int unsigned ACC_W   = COEF_W + MAX_BITS + 1
) (
  input  logic                         clk_i,
  input  logic                         rst_ni,
  input  logic                         load_i,
  input  logic [NUM_TAPS*MAX_BITS-1:0] samples_i,
  input  logic [IDX_W-1:0]             prec_i,
  input  logic                         tbl_we_i,
  input  logic [ADDR_W-1:0]            tbl_addr_i,
  input  logic [COEF_W-1:0]            tbl_data_i,
  input  logic                         start_i,
  output logic                         busy_o,
  output logic                         done_o,
  output logic [ACC_W-1:0]             result_o
);
  logic             accept, step, first, last, load_ok;
  logic [IDX_W-1:0] prec_q, align;
  logic [ADDR_W-1:0] slice;
  logic [COEF_W-1:0] entry;
  logic signed [ACC_W-1:0] res;
  da_pkg::acc_op_e   op;

  assign load_ok = load_i && !busy_o;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)      prec_q <= IDX_W'(MAX_BITS - 1);
    else if (load_ok) prec_q <= prec_i;
  end

  da_ctrl #(.IDX_W(IDX_W)) u_ctrl (
    .clk_i, .rst_ni, .start_i, .load_i, .prec_i(prec_q),
    .accept_o(accept), .step_o(step), .first_o(first), .last_o(last),
    .busy_o, .done_o
  );

  for (genvar i = 0; i < NUM_TAPS; i++) begin : g_tap
    da_slice_sreg #(.MAX_BITS(MAX_BITS), .IDX_W(IDX_W)) u_sreg (
      .clk_i, .rst_ni,
      .load_i(load_ok), .shift_i(step),
      .load_prec_i(prec_i), .run_prec_i(prec_q),
      .data_i(samples_i[i*MAX_BITS +: MAX_BITS]),
      .msb_o(slice[i])
    );
  end

  da_lut #(.ADDR_W(ADDR_W), .DATA_W(COEF_W)) u_lut (
    .clk_i, .rst_ni, .we_i(tbl_we_i), .waddr_i(tbl_addr_i), .wdata_i(tbl_data_i),
    .raddr_i(slice), .rdata_o(entry)
  );

  assign op    = first ? da_pkg::ACC_SUB : da_pkg::ACC_ADD;
  assign align = IDX_W'(MAX_BITS - 1) - prec_q;

  da_accum #(.COEF_W(COEF_W), .ACC_W(ACC_W), .IDX_W(IDX_W)) u_acc (
    .clk_i, .rst_ni, .clear_i(accept), .step_i(step), .op_i(op),
    .last_i(last), .entry_i(entry), .align_i(align), .result_o(res)
  );

  assign result_o = res;
endmodule

// File: rtl/da_unit_chk.sv
module da_unit_chk #(
  parameter int unsigned IDX_W = 3,
  parameter int unsigned RES_W = 21
) (
  input logic             clk_i,
  input logic             rst_ni,
  input logic             start_i,
  input logic             load_i,
  input logic             busy_o,
  input logic             done_o,
  input logic [RES_W-1:0] result_o,
  input logic [IDX_W-1:0] prec_q
);
  logic [IDX_W:0] run_cnt;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) run_cnt <= '0;
    else if (start_i && !load_i && !busy_o) run_cnt <= '0;
    else if (busy_o) run_cnt <= run_cnt + 1'b1;
  end

  AST_DONE_ONE_CYCLE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |=> !done_o);                                           // R5
  AST_DONE_WHEN_IDLE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |-> !busy_o);                                           // R5
  AST_START_TAKEN: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (start_i && !load_i && !busy_o) |=> busy_o);                   // R5
  AST_RUN_LENGTH: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |-> (run_cnt == {1'b0, prec_q} + 1'b1));                // R4
  AST_PREC_HELD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    busy_o |=> $stable(prec_q));                                   // R6
  AST_RESULT_HELD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    1'b1 |=> (done_o || $stable(result_o)));                       // R8
endmodule

bind da_unit da_unit_chk #(.IDX_W(IDX_W), .RES_W(ACC_W)) u_chk (
  .clk_i(clk_i), .rst_ni(rst_ni), .start_i(start_i), .load_i(load_i),
  .busy_o(busy_o), .done_o(done_o), .result_o(result_o), .prec_q(prec_q)
);

// File: tb/da_unit_tb_top.sv
`timescale 1ns/1ps
module da_unit_tb_top;
  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b0;
  logic        load_i = 1'b0;
  logic [31:0] samples_i = '0;
  logic [2:0]  prec_i = '0;
  logic        tbl_we_i = 1'b0;
  logic [3:0]  tbl_addr_i = '0;
  logic [11:0] tbl_data_i = '0;
  logic        start_i = 1'b0;
  logic        busy_o, done_o;
  logic [20:0] result_o;

  int n_total = 0;
  int n_fail  = 0;
  int coef [4];

  localparam logic [31:0] VEC [8] = '{
    32'h7F_7F_7F_7F, 32'h80_80_80_80, 32'h01_FF_7F_80, 32'h5A_A5_3C_C3,
    32'h00_00_00_00, 32'hFF_FF_FF_FF, 32'h12_ED_64_9B, 32'h80_7F_01_FE };

  always #5 clk_i = ~clk_i;

  da_unit dut_i (.*);

  task automatic chk(input bit ok, input string req, input longint act, input longint exp);
    n_total++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  function automatic int dot_ref(input logic [31:0] s, input int k);
    int sum = 0;
    for (int i = 0; i < 4; i++) begin
      int x, xt;
      x  = int'($signed(s[i*8 +: 8]));
      xt = (x >>> (8 - k)) <<< (8 - k);
      sum += coef[i] * xt;
    end
    return sum;
  endfunction

  task automatic fill_table(input int c0, input int c1, input int c2, input int c3);
    coef = '{c0, c1, c2, c3};
    for (int a = 0; a < 16; a++) begin
      int e = 0;
      for (int i = 0; i < 4; i++) if (a[i]) e += coef[i];
      tbl_we_i = 1'b1; tbl_addr_i = 4'(a); tbl_data_i = 12'(e);
      @(posedge clk_i); #1;
    end
    tbl_we_i = 1'b0;
  endtask

  // loads, starts and waits; returns negedges until done and the result
  task automatic run(input logic [31:0] s, input int k, output int lat, output int res);
    load_i = 1'b1; samples_i = s; prec_i = 3'(k - 1);
    @(posedge clk_i); #1;
    load_i = 1'b0; start_i = 1'b1;
    @(posedge clk_i); #1;
    start_i = 1'b0;
    lat = 0;
    for (int n = 1; n <= 20; n++) begin
      @(negedge clk_i);
      if (done_o) begin lat = n; break; end
    end
    res = int'($signed(result_o));
  endtask

  initial begin
    repeat (150000) @(posedge clk_i);
    n_total++; n_fail++;
    $display("FAIL R5 watchdog actual=running expected=finished");
    $display("%0d/%0d checks passed", n_total - n_fail, n_total);
    $finish;
  end

  initial begin
    int lat, res, exp, held, dones;
    repeat (3) @(posedge clk_i);
    #1 rst_ni = 1'b1;
    @(negedge clk_i);
    chk(busy_o == 1'b0, "R1 busy after reset", busy_o, 0);
    chk(done_o == 1'b0, "R1 done after reset", done_o, 0);
    chk(result_o == '0, "R1 result after reset", result_o, 0);
    @(posedge clk_i); #1;

    fill_table(300, -200, 450, -125);

    // R2 R3 R4 R5: every pattern at every precision
    for (int p = 0; p < 8; p++) begin
      for (int k = 1; k <= 8; k++) begin
        run(VEC[p], k, lat, res);
        exp = dot_ref(VEC[p], k);
        chk(res == exp, (k == 8) ? "R2 R3 full-precision result" : "R4 truncated result", res, exp);
        chk(lat == k + 1, "R5 done latency", lat, k + 1);
        @(negedge clk_i);
        chk(done_o == 1'b0 && busy_o == 1'b0, "R5 done single cycle", done_o, 0);
        @(posedge clk_i); #1;
      end
    end

    // R6: load while busy is ignored
    load_i = 1'b1; samples_i = VEC[2]; prec_i = 3'd7;
    @(posedge clk_i); #1;
    load_i = 1'b0; start_i = 1'b1;
    @(posedge clk_i); #1;
    start_i = 1'b0;
    @(posedge clk_i); #1;
    load_i = 1'b1; samples_i = VEC[0]; prec_i = 3'd0;
    @(posedge clk_i); #1;
    load_i = 1'b0;
    lat = 0;
    for (int n = 3; n <= 20; n++) begin
      @(negedge clk_i);
      if (done_o) begin lat = n; break; end
    end
    exp = dot_ref(VEC[2], 8);
    chk(int'($signed(result_o)) == exp, "R6 load during run ignored", $signed(result_o), exp);
    chk(lat == 9, "R6 run length kept", lat, 9);
    @(posedge clk_i); #1;

    // R7: start while busy neither restarts nor extends
    load_i = 1'b1; samples_i = VEC[3]; prec_i = 3'd7;
    @(posedge clk_i); #1;
    load_i = 1'b0; start_i = 1'b1;
    @(posedge clk_i); #1;
    start_i = 1'b0;
    dones = 0; lat = 0;
    for (int n = 1; n <= 20; n++) begin
      if (n == 4) start_i = 1'b1;
      @(negedge clk_i);
      if (n == 4) start_i = 1'b0;
      if (done_o) begin dones++; if (lat == 0) lat = n; end
    end
    chk(dones == 1, "R7 single completion", dones, 1);
    chk(lat == 9, "R7 completion time", lat, 9);
    exp = dot_ref(VEC[3], 8);
    chk(int'($signed(result_o)) == exp, "R7 result", $signed(result_o), exp);

    // R8: result holds between completions
    held = int'($signed(result_o));
    repeat (5) @(negedge clk_i);
    chk(int'($signed(result_o)) == held, "R8 result held", $signed(result_o), held);

    // R5: start with load in same idle cycle does not run
    @(posedge clk_i); #1;
    load_i = 1'b1; start_i = 1'b1; samples_i = VEC[1]; prec_i = 3'd7;
    @(posedge clk_i); #1;
    load_i = 1'b0; start_i = 1'b0;
    @(negedge clk_i);
    chk(busy_o == 1'b0, "R5 load wins over start", busy_o, 0);
    @(posedge clk_i); #1;

    // R9 R10: new table, extreme magnitudes
    fill_table(1023, 1024, -1024, -1023);
    run(32'h7F_7F_80_80, 8, lat, res);
    exp = dot_ref(32'h7F_7F_80_80, 8);
    chk(exp == -521985, "R10 reference", exp, -521985);
    chk(res == exp, "R10 extreme result", res, exp);
    @(posedge clk_i); #1;
    run(VEC[6], 8, lat, res);
    exp = dot_ref(VEC[6], 8);
    chk(res == exp, "R9 rewritten table", res, exp);
    @(posedge clk_i); #1;
    run(VEC[6], 3, lat, res);
    exp = dot_ref(VEC[6], 3);
    chk(res == exp, "R9 R4 rewritten table truncated", res, exp);

    $display("%0d/%0d checks passed", n_total - n_fail, n_total);
    $finish;
  end
endmodule